// File: doc/BRIEF.md
# Serial Port Interrupt Aggregator

This block gathers the interrupt events of one serial port channel into a single level interrupt line. It keeps a four-bit source register that latches receive, error, transmit and modem events. It also keeps a four-bit mask register. From these two it derives a registered pending register and the interrupt output. Software reads the three registers and writes them through a simple word-addressed register port. Writes to the source or pending register clear bits; writes to the mask register load it.

The transmit event has two origins. One is a pulse from the transmit data path when a byte has been accepted. The other is a threshold comparison: while the FIFOs are enabled, the transmit bit is raised whenever the transmit queue fill count is at or below a programmable trigger level. That level is the three-bit trigger field multiplied by a factor fixed by the channel number, which is a build parameter. The FIFOs and the shift logic are outside this block and supply the enable, trigger field, fill count and event pulses.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset the source, mask and pending registers all read zero and `irq` is low.
- R2: A one-cycle pulse on `evRx`, `evErr`, `txAccept` or `evModem` sets source bit 0, 1, 2 or 3 respectively at the next clock edge. The bit stays set until cleared.
- R3: At each edge the pending register loads the previous source value ANDed with the inverse of the previous mask value, so it trails both by one clock. `irq` is high exactly when some pending bit is set.
- R4: A write to the pending register at offset 0x30 clears, at the same edge, every bit written as one in both the source and the pending register.
- R5: A write to the source register at offset 0x34 clears the bits written as one. The pending register is not recomputed at that edge and follows one clock later.
- R6: A write to the mask register at offset 0x38 loads the four low data bits, which read back at the next cycle. The new mask reaches the pending register one clock later.
- R7: While `fifoEn` is high and `txCount` is at or below the trigger level, source bit 2 is set at the next edge. While `fifoEn` is low, the threshold sets nothing. `txTrig` carries bits 10:8 of the FIFO control register.
- R8: The trigger level is `txTrig` times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. Any other channel gives level 0.
- R9: When a set event and a clearing write hit the same source bit in the same cycle, the bit ends up set.
- R10: Reads at any offset other than 0x30, 0x34 and 0x38 return zero. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte offset |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | SRC_W | Write data (the four event bits) |
| busRdData | output | DATA_W | Read data of the addressed register, zero-extended |
| evRx | input | 1 | Receive event pulse |
| evErr | input | 1 | Error event pulse |
| evModem | input | 1 | Modem event pulse |
| txAccept | input | 1 | Transmit byte accepted pulse |
| fifoEn | input | 1 | FIFO enable bit of the FIFO control register |
| txTrig | input | 3 | Transmit trigger field, bits 10:8 of the FIFO control register |
| txCount | input | CNT_W | Transmit queue fill count |
| irq | output | 1 | Level interrupt output |

## Verification
The bench builds four copies of the block that share one bus: channel 1, channel 0, channel 3 and channel 6. Together they cover every multiplier, including the zero level of an unlisted channel. With an eight-bit count and a three-bit trigger field, every trigger and count pair is swept against all four copies, so each threshold edge is reached. The mask is swept through all sixteen values against a fully set source register. The register clearing paths, the one-cycle lags and the set-over-clear case are driven as directed sequences.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int SRC_W = 4;

  // Source bit positions
  localparam int BIT_RX    = 0;
  localparam int BIT_ERR   = 1;
  localparam int BIT_TX    = 2;
  localparam int BIT_MODEM = 3;

  // Register offsets
  localparam logic [7:0] OFS_PEND = 8'h30;
  localparam logic [7:0] OFS_SRC  = 8'h34;
  localparam logic [7:0] OFS_MASK = 8'h38;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEND = 2'd1,
    RD_SRC  = 2'd2,
    RD_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic             wrPend;
    logic             wrSrc;
    logic             wrMask;
    logic [SRC_W-1:0] data;
    logic [SRC_W-1:0] setSrc;
    rdSel_e           rdSel;
  } irqStrobe_t;

  function automatic int trigMult(input int channel);
    case (channel)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 8,
  parameter int CHANNEL = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [SRC_W-1:0]  busWrData,
  input  logic              evRx,
  input  logic              evErr,
  input  logic              evModem,
  input  logic              txAccept,
  input  logic              fifoEn,
  input  logic [2:0]        txTrig,
  input  logic [CNT_W-1:0]  txCount,
  output irqStrobe_t        strb
);

  localparam int MULT  = trigMult(CHANNEL);
  localparam int LVL_W = 9;
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CMP_W-1:0] levelVal;
  logic [CMP_W-1:0] countExt;
  logic             txBelow;
  logic             hitPend;
  logic             hitSrc;
  logic             hitMask;

  generate
    if (MULT == 0) begin : g_zeroLevel
      assign levelVal = '0;
    end else begin : g_scaledLevel
      assign levelVal = CMP_W'(txTrig) * CMP_W'(MULT);
    end
  endgenerate

  assign countExt = CMP_W'(txCount);
  assign txBelow  = fifoEn && (countExt <= levelVal);

  assign hitPend = (busAddr == ADDR_W'(OFS_PEND));
  assign hitSrc  = (busAddr == ADDR_W'(OFS_SRC));
  assign hitMask = (busAddr == ADDR_W'(OFS_MASK));

  always_comb begin
    strb                   = '0;
    strb.wrPend            = busWrEn && hitPend;
    strb.wrSrc             = busWrEn && hitSrc;
    strb.wrMask            = busWrEn && hitMask;
    strb.data              = busWrData;
    strb.setSrc[BIT_RX]    = evRx;
    strb.setSrc[BIT_ERR]   = evErr;
    strb.setSrc[BIT_TX]    = txAccept || txBelow;
    strb.setSrc[BIT_MODEM] = evModem;
    if (hitPend)      strb.rdSel = RD_PEND;
    else if (hitSrc)  strb.rdSel = RD_SRC;
    else if (hitMask) strb.rdSel = RD_MASK;
    else              strb.rdSel = RD_NONE;
  end

  // R10
  one_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrPend, strb.wrSrc, strb.wrMask}));

  // R7
  tx_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn && !txAccept) |-> !strb.setSrc[BIT_TX]);

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        strb,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);

  logic [SRC_W-1:0] srcQ;
  logic [SRC_W-1:0] maskQ;
  logic [SRC_W-1:0] pendQ;
  logic [SRC_W-1:0] srcClr;
  logic [SRC_W-1:0] pendClr;

  assign srcClr  = (strb.wrPend || strb.wrSrc) ? strb.data : '0;
  assign pendClr = strb.wrPend ? strb.data : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= '0;
      maskQ <= '0;
      pendQ <= '0;
    end else begin
      srcQ  <= (srcQ & ~srcClr) | strb.setSrc;
      pendQ <= srcQ & ~maskQ & ~pendClr;
      if (strb.wrMask) maskQ <= strb.data;
    end
  end

  assign irq = |pendQ;

  always_comb begin
    case (strb.rdSel)
      RD_PEND: busRdData = DATA_W'(pendQ);
      RD_SRC:  busRdData = DATA_W'(srcQ);
      RD_MASK: busRdData = DATA_W'(maskQ);
      default: busRdData = '0;
    endcase
  end

  // R3
  pend_subset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ & ~$past(srcQ)) == '0);

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrPend |=> ((srcQ | pendQ) & $past(strb.data & ~strb.setSrc)) == '0);

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> maskQ == $past(strb.data));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setSrc != '0) |=> (srcQ & $past(strb.setSrc)) == $past(strb.setSrc));

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int CHANNEL = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [SRC_W-1:0]  busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              evRx,
  input  logic              evErr,
  input  logic              evModem,
  input  logic              txAccept,
  input  logic              fifoEn,
  input  logic [2:0]        txTrig,
  input  logic [CNT_W-1:0]  txCount,
  output logic              irq
);

  irqStrobe_t strb;

  uart_irq_ctrl #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .CHANNEL (CHANNEL)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .evRx      (evRx),
    .evErr     (evErr),
    .evModem   (evModem),
    .txAccept  (txAccept),
    .fifoEn    (fifoEn),
    .txTrig    (txTrig),
    .txCount   (txCount),
    .strb      (strb)
  );

  uart_irq_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busRdData (busRdData),
    .irq       (irq)
  );

endmodule

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;

  localparam logic [7:0] A_PEND = 8'h30;
  localparam logic [7:0] A_SRC  = 8'h34;
  localparam logic [7:0] A_MASK = 8'h38;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busWrData = '0;
  logic        evRx = 1'b0, evErr = 1'b0, evModem = 1'b0, txAccept = 1'b0;
  logic        fifoEn = 1'b0;
  logic [2:0]  txTrig = '0;
  logic [7:0]  txCount = '0;
  logic [31:0] rdA, rdB, rdC, rdD;
  logic        irqA, irqB, irqC, irqD;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_unit #(.CHANNEL(1)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdA), .evRx(evRx), .evErr(evErr),
    .evModem(evModem), .txAccept(txAccept), .fifoEn(fifoEn),
    .txTrig(txTrig), .txCount(txCount), .irq(irqA));
  uart_irq_unit #(.CHANNEL(0)) dutC0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdB), .evRx(evRx), .evErr(evErr),
    .evModem(evModem), .txAccept(txAccept), .fifoEn(fifoEn),
    .txTrig(txTrig), .txCount(txCount), .irq(irqB));
  uart_irq_unit #(.CHANNEL(3)) dutC3 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdC), .evRx(evRx), .evErr(evErr),
    .evModem(evModem), .txAccept(txAccept), .fifoEn(fifoEn),
    .txTrig(txTrig), .txCount(txCount), .irq(irqC));
  uart_irq_unit #(.CHANNEL(6)) dutC6 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdD), .evRx(evRx), .evErr(evErr),
    .evModem(evModem), .txAccept(txAccept), .fifoEn(fifoEn),
    .txTrig(txTrig), .txCount(txCount), .irq(irqD));

  function automatic int expMult(input int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = rdA;
  endtask

  task automatic pulse(input logic [3:0] m);
    evRx = m[0]; evErr = m[1]; txAccept = m[2]; evModem = m[3];
    tick();
    evRx = 0; evErr = 0; txAccept = 0; evModem = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [3:0] prevMask;
    repeat (3) tick();
    rstN = 1'b1;

    // R1 reset state
    rd(A_SRC, v);  chk("R1 src", v, 0);
    rd(A_PEND, v); chk("R1 pend", v, 0);
    rd(A_MASK, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irqA}, 0);

    // R2 / R3 each event bit alone
    for (int i = 0; i < 4; i++) begin
      wr(A_SRC, 4'hF);
      tick();
      pulse(4'(1 << i));
      rd(A_SRC, v);  chk("R2 src bit", v, 32'(1 << i));
      rd(A_PEND, v); chk("R3 pend lag", v, 0);
      chk("R3 irq lag", {31'b0, irqA}, 0);
      tick();
      rd(A_PEND, v); chk("R3 pend", v, 32'(1 << i));
      chk("R3 irq", {31'b0, irqA}, 1);
    end

    // R6 / R3 mask sweep
    pulse(4'hF);
    tick();
    prevMask = 4'h0;
    for (int m = 0; m < 16; m++) begin
      wr(A_MASK, 4'(m));
      rd(A_MASK, v); chk("R6 mask readback", v, 32'(m));
      rd(A_PEND, v); chk("R6 pend lag", v, 32'(4'hF & ~prevMask));
      tick();
      rd(A_PEND, v); chk("R3 pend masked", v, 32'(4'hF & ~4'(m)));
      chk("R3 irq masked", {31'b0, irqA}, 32'(m != 15));
      prevMask = 4'(m);
    end

    // R4 pending write clears both
    wr(A_MASK, 4'h0);
    tick();
    rd(A_PEND, v); chk("R4 pend before", v, 32'hF);
    wr(A_PEND, 4'h5);
    rd(A_SRC, v);  chk("R4 src cleared", v, 32'hA);
    rd(A_PEND, v); chk("R4 pend cleared", v, 32'hA);
    tick();
    rd(A_PEND, v); chk("R4 pend stays", v, 32'hA);

    // R5 source write, pending follows later
    pulse(4'hF);
    tick();
    rd(A_PEND, v); chk("R5 pend before", v, 32'hF);
    wr(A_SRC, 4'h3);
    rd(A_SRC, v);  chk("R5 src cleared", v, 32'hC);
    rd(A_PEND, v); chk("R5 pend not yet", v, 32'hF);
    tick();
    rd(A_PEND, v); chk("R5 pend follows", v, 32'hC);

    // R9 set beats clear
    wr(A_SRC, 4'hF);
    busAddr = A_SRC; busWrData = 4'h3; busWrEn = 1'b1; evRx = 1'b1;
    tick();
    busWrEn = 1'b0; evRx = 1'b0; busAddr = '0;
    rd(A_SRC, v); chk("R9 set wins", v, 32'h1);

    // R10 unmapped offsets
    wr(A_MASK, 4'h0);
    wr(8'h3C, 4'hF);
    wr(8'h00, 4'hF);
    rd(A_MASK, v); chk("R10 mask untouched", v, 0);
    rd(A_SRC, v);  chk("R10 src untouched", v, 32'h1);
    rd(8'h3C, v);  chk("R10 read zero", v, 0);
    rd(8'h2C, v);  chk("R10 read zero low", v, 0);

    // R7 disabled threshold sets nothing
    wr(A_SRC, 4'hF);
    fifoEn = 1'b0; txTrig = 3'd7; txCount = 8'd0;
    tick();
    rd(A_SRC, v); chk("R7 disabled", v, 0);

    // R7 / R8 full trigger x count sweep, four channels
    for (int f = 0; f < 8; f++) begin
      for (int c = 0; c < 256; c++) begin
        fifoEn = 1'b0;
        wr(A_SRC, 4'h4);
        fifoEn = 1'b1; txTrig = 3'(f); txCount = 8'(c);
        tick();
        busAddr = A_SRC;
        #1;
        chk("R8 ch1 tx", 32'(rdA[2]), 32'(c <= f * expMult(1)));
        chk("R8 ch0 tx", 32'(rdB[2]), 32'(c <= f * expMult(0)));
        chk("R7 ch3 tx", 32'(rdC[2]), 32'(c <= f * expMult(3)));
        chk("R8 ch6 tx", 32'(rdD[2]), 32'(c <= f * expMult(6)));
      end
    end
    fifoEn = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule